// File: doc/BRIEF.md
# External Sync Clock Qualifier and Source Selector

This block decides whether a switching regulator takes its switching clock from the internal RC oscillator or from an external synchronization input. It samples the external clock in the reference clock domain and counts rising edges over a fixed window of reference cycles. The external clock is accepted only when that count falls inside a band around the programmed nominal frequency, and a change of verdict needs two windows in a row that agree.

A 2-bit mode and the device's operating state set whether the qualifier runs at all. While it runs, the block follows the verdict: it selects the external clock once the clock qualifies and drops back to the RC clock when the clock is lost, and each switch latches a sticky event flag. A second sticky flag reports an external clock that is expected but missing after the device enters standby or active. The block drives a combined interrupt output, and the event flag can be masked from that output.

Top module: `sync_clk_monitor`

## Requirements
- R1: After reset `use_ext`, `sync_flag`, `nosync_flag` and `irq` are all 0.
- R2: With `mode` 0 or 3 the qualifier is off. `use_ext` stays 0 and `sync_flag` does not set, whatever the external clock does.
- R3: `op_state` encodes 0 startup, 1 standby, 2 or 3 active. Mode 1 enables qualification in standby and active. Mode 2 enables it only in active, so `use_ext` is 0 in standby.
- R4: The nominal frequency is N = `freq_code`+1 MHz, and codes 23 to 31 all mean 24 MHz. A window of WIN_CYCLES reference cycles with E edges is in range when 10·REF_MHZ·E lies between 7·N·WIN_CYCLES and 11·N·WIN_CYCLES inclusive, which is 70 % to 110 % of nominal.
- R5: With detection enabled, `use_ext` changes only after two consecutive windows disagree with it. A single window out of range leaves it unchanged.
- R6: A window with no edges at all clears `use_ext` at once, without waiting for a second window.
- R7: While detection is enabled, every change of `use_ext` sets `sync_flag`. When detection is switched off, `use_ext` drops to 0 and `sync_flag` does not set.
- R8: A one-cycle pulse on `clr_sync` clears `sync_flag`, and a pulse on `clr_nosync` clears `nosync_flag`. A flag falls only through its clear input.
- R9: `irq` is 1 when `sync_flag` is set and `sync_mask` is 0, or when `nosync_flag` is set. `sync_mask` has no effect on `nosync_flag`.
- R10: A step from startup to standby in mode 1, or from standby to active in mode 2, arms a missing-clock check. If the external clock has not qualified by the end of GRACE_WINS windows, `nosync_flag` sets. No other step arms the check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (time base) |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | External synchronization clock (asynchronous) |
| mode | input | 2 | Detection mode select |
| freq_code | input | 5 | Nominal external frequency code |
| op_state | input | 2 | Device operating state: 0 startup, 1 standby, 2/3 active |
| sync_mask | input | 1 | Masks `sync_flag` from `irq` |
| clr_sync | input | 1 | Write-one-to-clear pulse for `sync_flag` |
| clr_nosync | input | 1 | Write-one-to-clear pulse for `nosync_flag` |
| use_ext | output | 1 | 1 selects the external clock, 0 the RC clock |
| sync_flag | output | 1 | Sticky flag: the external clock appeared or disappeared |
| nosync_flag | output | 1 | Sticky flag: the expected external clock is missing |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench sets REF_MHZ to 125 to match its clock, WIN_CYCLES to 1000 and GRACE_WINS to 3. At a 10 MHz nominal the window then expects 80 edges, and both limits, 56 and 88, are whole counts. Test frequencies of 7.1, 6.8, 10.9 and 11.2 MHz therefore land one or two edges from each limit. Each qualification takes a few thousand cycles, so every mode, state step, mask and clamp case fits in one run. A short burst of fast edges that spoils only one window checks that a single bad window does not change the selection.

// File: rtl/sync_clk_monitor.sv
module sync_clk_monitor #(
  parameter int REF_MHZ    = 128,
  parameter int WIN_CYCLES = 2048,
  parameter int GRACE_WINS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_clk,
  input  logic [1:0] mode,
  input  logic [4:0] freq_code,
  input  logic [1:0] op_state,
  input  logic       sync_mask,
  input  logic       clr_sync,
  input  logic       clr_nosync,
  output logic       use_ext,
  output logic       sync_flag,
  output logic       nosync_flag,
  output logic       irq
);
  localparam int CW = $clog2(WIN_CYCLES);
  localparam int EW = $clog2(WIN_CYCLES) + 1;
  localparam int GW = $clog2(GRACE_WINS + 1);
  localparam int PW = 48;

  logic [2:0]    ext_sr;
  logic [CW-1:0] win_cnt;
  logic [EW-1:0] edge_cnt;
  logic [1:0]    prev_state;
  logic          disagree, disagree_nxt, valid_nxt;
  logic          pend;
  logic [GW-1:0] grace;

  wire ext_edge = ext_sr[1] & ~ext_sr[2];
  wire det_en   = (mode == 2'd1) ? (op_state != 2'd0) :
                  (mode == 2'd2) ? op_state[1] : 1'b0;
  wire win_end  = det_en && (win_cnt == CW'(WIN_CYCLES - 1));
  wire [4:0] nom = (freq_code > 5'd22) ? 5'd24 : freq_code + 5'd1;
  wire [EW-1:0] meas = edge_cnt + EW'(ext_edge);

  wire [PW-1:0] scaled = PW'(meas) * PW'(10 * REF_MHZ);
  wire [PW-1:0] lo_lim = PW'(7 * WIN_CYCLES) * PW'(nom);
  wire [PW-1:0] hi_lim = PW'(11 * WIN_CYCLES) * PW'(nom);
  wire in_rng = (meas != '0) && (scaled >= lo_lim) && (scaled <= hi_lim);

  wire to_stby = (prev_state == 2'd0) && (op_state == 2'd1);
  wire to_act  = (prev_state == 2'd1) && op_state[1];
  wire arm     = (to_stby && mode == 2'd1) || (to_act && mode == 2'd2);
  wire miss    = pend && !arm && det_en && !valid_nxt && win_end &&
                 (grace == GW'(GRACE_WINS - 1));

  always_comb begin
    valid_nxt    = use_ext;
    disagree_nxt = disagree;
    if (!det_en) begin
      valid_nxt    = 1'b0;
      disagree_nxt = 1'b0;
    end else if (win_end) begin
      if (meas == '0) begin
        valid_nxt    = 1'b0;
        disagree_nxt = 1'b0;
      end else if (in_rng != use_ext) begin
        if (disagree) begin
          valid_nxt    = in_rng;
          disagree_nxt = 1'b0;
        end else begin
          disagree_nxt = 1'b1;
        end
      end else begin
        disagree_nxt = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_sr     <= '0;
      win_cnt    <= '0;
      edge_cnt   <= '0;
      prev_state <= '0;
      use_ext    <= 1'b0;
      disagree   <= 1'b0;
      sync_flag  <= 1'b0;
      nosync_flag <= 1'b0;
      pend       <= 1'b0;
      grace      <= '0;
    end else begin
      ext_sr     <= {ext_sr[1:0], ext_clk};
      prev_state <= op_state;
      use_ext    <= valid_nxt;
      disagree   <= disagree_nxt;

      if (!det_en || win_end) begin
        win_cnt  <= '0;
        edge_cnt <= '0;
      end else begin
        win_cnt  <= win_cnt + 1'b1;
        edge_cnt <= meas;
      end

      if (det_en && (valid_nxt != use_ext)) sync_flag <= 1'b1;
      else if (clr_sync)                    sync_flag <= 1'b0;

      if (miss)            nosync_flag <= 1'b1;
      else if (clr_nosync) nosync_flag <= 1'b0;

      if (arm) begin
        pend  <= 1'b1;
        grace <= '0;
      end else if (pend) begin
        if (!det_en || valid_nxt || miss) pend <= 1'b0;
        else if (win_end)                 grace <= grace + 1'b1;
      end
    end
  end

  assign irq = (sync_flag && !sync_mask) || nosync_flag;
endmodule

// File: rtl/sync_clk_monitor_chk.sv
module sync_clk_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic [1:0] op_state,
  input logic       sync_mask,
  input logic       clr_sync,
  input logic       clr_nosync,
  input logic       use_ext,
  input logic       sync_flag,
  input logic       nosync_flag,
  input logic       irq
);
  // R2
  mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'd0 || mode == 2'd3) && $past(mode == 2'd0 || mode == 2'd3)) |-> !use_ext);

  // R3
  stby_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && $past(mode == 2'd2) && op_state == 2'd1 && $past(op_state == 2'd1))
      |-> !use_ext);

  // R7
  flag_on_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_flag) |-> (use_ext != $past(use_ext)));

  // R8
  sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_flag) |-> $past(clr_sync));

  // R8
  nosync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nosync_flag) |-> $past(clr_nosync));

  // R9
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mask && !nosync_flag) |-> !irq);

  // R9
  nosync_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nosync_flag |-> irq);

  // R10
  miss_no_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nosync_flag) |-> !use_ext);
endmodule

bind sync_clk_monitor sync_clk_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .op_state(op_state),
  .sync_mask(sync_mask), .clr_sync(clr_sync), .clr_nosync(clr_nosync),
  .use_ext(use_ext), .sync_flag(sync_flag), .nosync_flag(nosync_flag), .irq(irq)
);

// File: tb/sync_clk_monitor_tb.sv
`timescale 1ns/1ps
module sync_clk_monitor_tb;
  logic clk = 0, rst_n = 0, ext_clk = 0;
  logic [1:0] mode = 0, op_state = 0;
  logic [4:0] freq_code = 5'd4;
  logic sync_mask = 0, clr_sync = 0, clr_nosync = 0;
  logic use_ext, sync_flag, nosync_flag, irq;
  int n_chk = 0, n_bad = 0;
  bit ext_on = 0;
  real half_ns = 100.0;
  localparam int SETTLE = 3500;

  always #4 clk = ~clk;

  initial forever begin
    if (ext_on) begin
      ext_clk = 1; #(half_ns);
      ext_clk = 0; #(half_ns);
    end else begin
      ext_clk = 0; #8;
    end
  end

  sync_clk_monitor #(.REF_MHZ(125), .WIN_CYCLES(1000), .GRACE_WINS(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .mode(mode), .freq_code(freq_code),
    .op_state(op_state), .sync_mask(sync_mask), .clr_sync(clr_sync),
    .clr_nosync(clr_nosync), .use_ext(use_ext), .sync_flag(sync_flag),
    .nosync_flag(nosync_flag), .irq(irq));

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ext(real mhz);
    if (mhz == 0.0) ext_on = 0;
    else begin half_ns = 500.0 / mhz; ext_on = 1; end
  endtask

  task automatic pulse_clr_sync();
    @(negedge clk) clr_sync = 1;
    @(negedge clk) clr_sync = 0;
    @(negedge clk);
  endtask

  task automatic pulse_clr_nosync();
    @(negedge clk) clr_nosync = 1;
    @(negedge clk) clr_nosync = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    cyc(3);
    chk("R1", "use_ext", use_ext, 0);
    chk("R1", "sync_flag", sync_flag, 0);
    chk("R1", "nosync_flag", nosync_flag, 0);
    chk("R1", "irq", irq, 0);
  endtask

  task automatic t_mode_off();
    op_state = 2; set_ext(5.0);
    mode = 0; cyc(SETTLE);
    chk("R2", "mode0 use_ext", use_ext, 0);
    chk("R2", "mode0 sync_flag", sync_flag, 0);
    mode = 3; cyc(SETTLE);
    chk("R2", "mode3 use_ext", use_ext, 0);
    chk("R2", "mode3 sync_flag", sync_flag, 0);
  endtask

  task automatic t_appear_clear();
    mode = 1; cyc(SETTLE);
    chk("R3", "mode1 active use_ext", use_ext, 1);
    chk("R7", "appear sync_flag", sync_flag, 1);
    chk("R9", "irq unmasked", irq, 1);
    pulse_clr_sync();
    chk("R8", "sync_flag cleared", sync_flag, 0);
    chk("R9", "irq after clear", irq, 0);
    chk("R8", "use_ext kept", use_ext, 1);
  endtask

  task automatic t_mask_low();
    sync_mask = 1; set_ext(3.0); cyc(SETTLE);
    chk("R4", "3MHz low use_ext", use_ext, 0);
    chk("R7", "disappear sync_flag", sync_flag, 1);
    chk("R9", "masked irq", irq, 0);
    sync_mask = 0; cyc(1);
    chk("R9", "unmasked irq", irq, 1);
    pulse_clr_sync();
  endtask

  task automatic t_high();
    set_ext(5.0); cyc(SETTLE);
    chk("R4", "5MHz nominal use_ext", use_ext, 1);
    set_ext(6.0); cyc(SETTLE);
    chk("R4", "6MHz high use_ext", use_ext, 0);
    pulse_clr_sync();
  endtask

  task automatic t_bounds();
    freq_code = 5'd9;
    set_ext(7.1); cyc(SETTLE);
    chk("R4", "7.1MHz at low edge", use_ext, 1);
    set_ext(6.8); cyc(SETTLE);
    chk("R4", "6.8MHz below", use_ext, 0);
    set_ext(10.9); cyc(SETTLE);
    chk("R4", "10.9MHz at high edge", use_ext, 1);
    set_ext(11.2); cyc(SETTLE);
    chk("R4", "11.2MHz above", use_ext, 0);
    set_ext(10.0); cyc(SETTLE);
    pulse_clr_sync();
  endtask

  task automatic t_one_bad_window();
    set_ext(25.0); cyc(100);
    set_ext(10.0); cyc(2500);
    chk("R5", "single bad window use_ext", use_ext, 1);
    chk("R5", "single bad window sync_flag", sync_flag, 0);
  endtask

  task automatic t_no_edges();
    set_ext(0.0); cyc(2500);
    chk("R6", "no edges use_ext", use_ext, 0);
    chk("R7", "no edges sync_flag", sync_flag, 1);
    pulse_clr_sync();
  endtask

  task automatic t_clamp();
    freq_code = 5'd31; set_ext(24.0); cyc(SETTLE);
    chk("R4", "code31 at 24MHz", use_ext, 1);
    set_ext(0.0); cyc(SETTLE);
    pulse_clr_sync();
    freq_code = 5'd4;
  endtask

  task automatic t_mode2();
    mode = 2; op_state = 0; set_ext(5.0); cyc(10);
    op_state = 1; cyc(SETTLE);
    chk("R3", "mode2 standby use_ext", use_ext, 0);
    chk("R10", "mode2 startup step no nosync", nosync_flag, 0);
    op_state = 2; cyc(SETTLE);
    chk("R3", "mode2 active use_ext", use_ext, 1);
    chk("R10", "clock present no nosync", nosync_flag, 0);
    pulse_clr_sync();
    op_state = 1; cyc(20);
    chk("R7", "disable drops use_ext", use_ext, 0);
    chk("R7", "disable no sync_flag", sync_flag, 0);
    set_ext(0.0); sync_mask = 1; cyc(10);
    op_state = 2; cyc(SETTLE);
    chk("R10", "mode2 missing nosync", nosync_flag, 1);
    chk("R9", "nosync ignores mask", irq, 1);
    pulse_clr_nosync();
    chk("R8", "nosync cleared", nosync_flag, 0);
    sync_mask = 0;
  endtask

  task automatic t_mode1_start();
    mode = 1; op_state = 0; set_ext(0.0); cyc(10);
    op_state = 1; cyc(SETTLE);
    chk("R10", "mode1 missing nosync", nosync_flag, 1);
    pulse_clr_nosync();
    op_state = 0; set_ext(5.0); cyc(10);
    op_state = 1; cyc(SETTLE);
    chk("R10", "mode1 present no nosync", nosync_flag, 0);
    chk("R3", "mode1 standby use_ext", use_ext, 1);
  endtask

  initial begin
    cyc(4); rst_n = 1;
    t_reset();
    t_mode_off();
    t_appear_clear();
    t_mask_low();
    t_high();
    t_bounds();
    t_one_bad_window();
    t_no_edges();
    t_clamp();
    t_mode2();
    t_mode1_start();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(190000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule